// File: doc/BRIEF.md
# Shift, Rotate and Mask Unit

This block is a 32-bit bit-manipulation datapath. Packet-processing cores use it to pull fields out of header words. One operation code picks the function. The choices are:

- a left shift, a logical right shift or an arithmetic right shift, with the amount taken from an immediate field or from a register;
- a single-step rotate-right followed by masking from both sides;
- a shift followed by a complementary mask whose bound comes from a register.

Each request is presented with a valid strobe. The result appears on a registered output, with its own valid flag, one clock later. Instruction decoding and the register file belong to the surrounding core. The core supplies the data operand, the register value, the 5-bit immediate amount and the 5-bit left-mask count directly.

Top module: `srm_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `result` are cleared to zero at that edge.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `result` loads only when `in_valid` is high and holds its value otherwise.
- R3: Immediate shifts shift `data_in` by `shamt`. Code 0 is a left shift, code 1 is a logical right shift and code 2 is an arithmetic right shift.
- R4: Variable shifts use only `reg_val[4:0]` as the amount. Code 3 is a left shift, code 4 is a logical right shift and code 5 is an arithmetic right shift. Bits 31:5 of `reg_val` have no effect on the result.
- R5: Arithmetic right shifts fill the vacated upper bits with copies of `data_in[31]`. Logical shifts fill vacated bits with zero.
- R6: Code 6, rotate-and-mask, gives `ror(data_in, shamt) & (32'hFFFFFFFF >> lmask) & (32'hFFFFFFFF << reg_val[4:0])`.
- R7: Code 7, shift-left-and-mask, gives `(data_in << shamt) & (32'hFFFFFFFF >> reg_val[4:0])`.
- R8: Code 8, shift-right-and-mask, gives `(data_in >> shamt) & (32'hFFFFFFFF << reg_val[4:0])`, where the shift is logical.
- R9: When the shift or rotate amount is zero, `data_in` reaches the masking stage unchanged. For code 6 with all counts zero, the result equals `data_in`.
- R10: Codes 9 to 15 produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation code (see R3 to R10) |
| data_in | input | 32 | Data operand |
| reg_val | input | 32 | Register amount or mask bound (low 5 bits used) |
| shamt | input | 5 | Immediate shift or rotate amount |
| lmask | input | 5 | Left-mask count for rotate-and-mask |
| out_valid | output | 1 | Result valid, one clock after the request |
| result | output | 32 | Registered result |

## Verification
The bench builds the unit with its default width of 32 bits. At that width the 5-bit amounts reach every position, so the bench can drive the full-width cases: shifts of 31 and masks that remove all but one bit. Directed requests cover sign fill, zero amounts, register values with noisy upper bits and unused codes. They are followed by a long stream of random requests with gaps between them, checked against a reference model.

// File: rtl/srm_pkg.sv
// Shared types for the shift, rotate and mask unit.
// Assumes a 4-bit operation code; codes above SRM_SRMASK are treated as unused.
package srm_pkg;
    typedef enum logic [3:0] {
        SRM_SLL_I  = 4'd0,
        SRM_SRL_I  = 4'd1,
        SRM_SRA_I  = 4'd2,
        SRM_SLL_V  = 4'd3,
        SRM_SRL_V  = 4'd4,
        SRM_SRA_V  = 4'd5,
        SRM_ROTMSK = 4'd6,
        SRM_SLMASK = 4'd7,
        SRM_SRMASK = 4'd8
    } srm_op_e;

    // Control word produced by the decoder for the datapath.
    typedef struct packed {
        logic       use_reg_amt;
        logic       dir_left;
        logic       arith;
        logic       rotate;
        logic       hi_en;
        logic       hi_from_reg;
        logic       lo_en;
        logic       zero_out;
    } srm_ctrl_t;
endpackage

// File: rtl/srm_decode.sv
// Operation decoder: turns an operation code into datapath control.
// Assumes the package encoding; an unknown code sets zero_out.
module srm_decode
    import srm_pkg::*;
(
    input  logic [3:0] op_sel,
    output srm_ctrl_t  ctrl
);
    // Map each code to its control bits.
    always_comb begin
        ctrl = '0;
        case (op_sel)
            SRM_SLL_I:  ctrl.dir_left = 1'b1;
            SRM_SRL_I:  ctrl.dir_left = 1'b0;
            SRM_SRA_I:  ctrl.arith    = 1'b1;
            SRM_SLL_V: begin
                ctrl.use_reg_amt = 1'b1;
                ctrl.dir_left    = 1'b1;
            end
            SRM_SRL_V:  ctrl.use_reg_amt = 1'b1;
            SRM_SRA_V: begin
                ctrl.use_reg_amt = 1'b1;
                ctrl.arith       = 1'b1;
            end
            SRM_ROTMSK: begin
                ctrl.rotate = 1'b1;
                ctrl.hi_en  = 1'b1;
                ctrl.lo_en  = 1'b1;
            end
            SRM_SLMASK: begin
                ctrl.dir_left    = 1'b1;
                ctrl.hi_en       = 1'b1;
                ctrl.hi_from_reg = 1'b1;
            end
            SRM_SRMASK: ctrl.lo_en = 1'b1;
            default:    ctrl.zero_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/srm_shift_core.sv
// Log-depth barrel shifter: right shift or rotate, with sign or zero fill.
// A left shift reverses the bits, shifts right, then reverses back.
// Assumes W is a power of two and AW = log2(W); rotate is used only rightward.
module srm_shift_core #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    input  logic [AW-1:0] amt,
    input  logic          dir_left,
    input  logic          arith,
    input  logic          rotate,
    output logic [W-1:0]  q
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [0:AW];
    logic         fill;

    // Bit reversal on the way in and out for left shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = d[W-1-i];
        assign rev_out[i] = stage[AW][W-1-i];
    end

    assign fill     = arith & ~dir_left & d[W-1];
    assign stage[0] = dir_left ? rev_in : d;

    // One stage per amount bit, each moving by a power of two.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stage[k+1] = !amt[k] ? stage[k] :
                            rotate  ? {stage[k][S-1:0], stage[k][W-1:S]} :
                                      {{S{fill}}, stage[k][W-1:S]};
    end

    assign q = dir_left ? rev_out : stage[AW];
endmodule

// File: rtl/srm_mask_gen.sv
// Two-sided mask: the upper bound clears high bits, the lower bound clears low bits.
// A disabled side contributes all ones.
module srm_mask_gen #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [AW-1:0] hi_cnt,
    input  logic [AW-1:0] lo_cnt,
    input  logic          hi_en,
    input  logic          lo_en,
    output logic [W-1:0]  mask
);
    localparam logic [W-1:0] ONES = '1;
    logic [W-1:0] hi_part;
    logic [W-1:0] lo_part;

    // Build each side, then combine them.
    always_comb begin
        hi_part = hi_en ? (ONES >> hi_cnt) : ONES;
        lo_part = lo_en ? (ONES << lo_cnt) : ONES;
        mask    = hi_part & lo_part;
    end
endmodule

// File: rtl/srm_unit.sv
// Shift, rotate and mask unit: one decode, one barrel shifter, one mask,
// then a single output register loaded on in_valid.
// Assumes only reg_val[AW-1:0] carries meaning; reset is synchronous, active low.
module srm_unit
    import srm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [AW-1:0]     shamt,
    input  logic [AW-1:0]     lmask,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    srm_ctrl_t         ctrl;
    logic [AW-1:0]     reg_amt;
    logic [AW-1:0]     amt;
    logic [AW-1:0]     hi_cnt;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] next_res;
    logic              unused_reg_hi;

    assign reg_amt       = reg_val[AW-1:0];
    assign unused_reg_hi = ^reg_val[DATA_W-1:AW];

    srm_decode u_dec (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    // Pick the shift amount source.
    assign amt    = ctrl.use_reg_amt ? reg_amt : shamt;
    // Pick the upper-bound count source.
    assign hi_cnt = ctrl.hi_from_reg ? reg_amt : lmask;

    srm_shift_core #(.W(DATA_W), .AW(AW)) u_shift (
        .d        (data_in),
        .amt      (amt),
        .dir_left (ctrl.dir_left),
        .arith    (ctrl.arith),
        .rotate   (ctrl.rotate),
        .q        (shifted)
    );

    srm_mask_gen #(.W(DATA_W), .AW(AW)) u_mask (
        .hi_cnt (hi_cnt),
        .lo_cnt (reg_amt),
        .hi_en  (ctrl.hi_en),
        .lo_en  (ctrl.lo_en),
        .mask   (mask)
    );

    // Apply the mask, or force zero for unused codes.
    assign next_res = ctrl.zero_out ? '0 : (shifted & mask);

    // Output register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end
endmodule

// File: rtl/srm_checker.sv
// Property checker for srm_unit, attached with bind.
module srm_checker #(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] reg_val,
    input logic [AW-1:0]     shamt,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> $stable(result));

    p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd2 && data_in[DATA_W-1]) |=> result[DATA_W-1]);

    p_srl_zero_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd1 && shamt != '0) |=> !result[DATA_W-1]);

    p_sll_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd0 && shamt != '0) |=> !result[0]);

    p_slmask_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7 && reg_val[AW-1:0] != '0) |=> !result[DATA_W-1]);

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > 4'd8) |=> result == '0);
endmodule

bind srm_unit srm_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .data_in   (data_in),
    .reg_val   (reg_val),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/srm_unit_tb.sv
module srm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] data_in = '0;
    logic [31:0] reg_val = '0;
    logic [4:0]  shamt = '0;
    logic [4:0]  lmask = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    srm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .data_in(data_in), .reg_val(reg_val), .shamt(shamt), .lmask(lmask),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] d,
        input logic [31:0] r, input logic [4:0] s, input logic [4:0] lm);
        logic [31:0] ones = 32'hFFFF_FFFF;
        logic [4:0]  rc = r[4:0];
        logic [31:0] rot = (d >> s) | (d << (6'd32 - {1'b0, s}));
        case (op)
            4'd0: return d << s;
            4'd1: return d >> s;
            4'd2: return 32'($signed(d) >>> s);
            4'd3: return d << rc;
            4'd4: return d >> rc;
            4'd5: return 32'($signed(d) >>> rc);
            4'd6: return rot & (ones >> lm) & (ones << rc);
            4'd7: return (d << s) & (ones >> rc);
            4'd8: return (d >> s) & (ones << rc);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected value queued.
    task automatic send(input string tag, input logic [3:0] op, input logic [31:0] d,
        input logic [31:0] r, input logic [4:0] s, input logic [4:0] lm);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; data_in = d; reg_val = r; shamt = s; lmask = lm;
        exp_q.push_back(ref_model(op, d, r, s, lm));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each produced result with the queue head.
    always begin
        @(posedge clk);
        #1;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected valid", 32'h1, 32'h0);
            else check(tag_q.pop_front(), result, exp_q.pop_front());
        end
    end

    initial begin
        bit timed_out = 0;
        fork
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
            begin
                repeat (3) @(posedge clk);
                #1;
                check("R1 reset valid", {31'h0, out_valid}, 32'h0);
                check("R1 reset result", result, 32'h0);
                @(negedge clk);
                rst_n = 1'b1;
                send("R3 sll imm", 4'd0, 32'h0000_00F1, 32'h0, 5'd31, 5'd0);
                send("R3 srl imm", 4'd1, 32'h8000_0000, 32'h0, 5'd31, 5'd0);
                send("R5 sra sign", 4'd2, 32'h8000_1234, 32'h0, 5'd4, 5'd0);
                send("R5 sra positive", 4'd2, 32'h7000_0000, 32'h0, 5'd28, 5'd0);
                send("R4 var shift hi bits", 4'd4, 32'hF000_0000, 32'hFFFF_FFE4, 5'd0, 5'd0);
                send("R4 var sra", 4'd5, 32'h9000_0000, 32'h1234_5663, 5'd9, 5'd0);
                send("R4 var sll", 4'd3, 32'h0000_0001, 32'hFFFF_FFFF, 5'd1, 5'd0);
                send("R6 rot mask", 4'd6, 32'h1234_5678, 32'h0000_0004, 5'd8, 5'd8);
                send("R6 rot single bit", 4'd6, 32'hFFFF_FFFF, 32'h0000_001F, 5'd3, 5'd0);
                send("R9 zero amounts", 4'd6, 32'hDEAD_BEEF, 32'h0, 5'd0, 5'd0);
                send("R9 zero shift", 4'd1, 32'hCAFE_F00D, 32'h0, 5'd0, 5'd0);
                send("R7 sl mask", 4'd7, 32'hABCD_EF01, 32'h0000_0008, 5'd4, 5'd0);
                send("R8 sr mask", 4'd8, 32'hABCD_EF01, 32'hFFFF_FFE8, 5'd4, 5'd0);
                send("R10 unused code", 4'd12, 32'hFFFF_FFFF, 32'h3, 5'd1, 5'd1);
                send("R10 unused code 9", 4'd9, 32'h1234_5678, 32'h0, 5'd0, 5'd0);
                // Hold check: result unchanged across idle cycles.
                send("R2 before hold", 4'd0, 32'h0000_0003, 32'h0, 5'd2, 5'd0);
                begin
                    logic [31:0] kept;
                    @(posedge clk); #1;
                    kept = result;
                    op_sel = 4'd1; data_in = 32'hFFFF_FFFF;
                    repeat (3) @(posedge clk);
                    #1;
                    check("R2 hold", result, kept);
                    check("R2 idle valid", {31'h0, out_valid}, 32'h0);
                end
                // Random stream with gaps.
                for (int i = 0; i < 400; i++) begin
                    logic [3:0] op = 4'($urandom_range(0, 10));
                    send("R3-R8 random", op, $urandom, $urandom, 5'($urandom), 5'($urandom));
                    if ($urandom_range(0, 3) == 0) @(negedge clk);
                end
                repeat (4) @(posedge clk);
                #2;
                check("R2 queue drained", 32'(exp_q.size()), 32'h0);
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule